// File: doc/BRIEF.md
# Dual-Strobe Multiplexed DRAM Model

This block is a synthesizable, cycle-level model of a 16-bit-wide dynamic memory with a multiplexed address bus. A system clock samples the active-low strobes: row strobe, lower and upper column strobes, write enable and output enable. Every event is taken from the difference between two consecutive samples. The row address is latched when the row strobe falls. The column address is taken when the first column strobe falls. Each column strobe owns one byte lane of the data bus. The data bus is split into an input port and an output port, with one drive-enable per lane.

The model supports byte-lane reads, early writes, delayed writes and read-modify-write, page-mode column changes while the row is held open, refresh with the column strobe before the row strobe (driven by an internal 9-bit row counter), and refresh with the row strobe only. The stored array is smaller than the full 18-bit address space. Only the low `ROW_KEEP` bits of the row and the low `COL_KEEP` bits of the column select a word, so addresses that differ only in the higher bits alias to the same word. A debug pulse marks a column strobe that went low and then high again while the row strobe stayed high.

Top module: `dram_dual_strobe`

## Requirements
- R1: A row strobe fall with both column strobes high latches `addr` as the row. The first column strobe fall after it selects the column. The word used is index {row[ROW_KEEP-1:0], col[COL_KEEP-1:0]}, 4 bits each by default.
- R2: The lower strobe `lcas_n` owns bits 7:0 and `dq_oe[0]`. The upper strobe `ucas_n` owns bits 15:8 and `dq_oe[1]`. Only lanes whose strobe is low are driven or written. An undriven lane reads 0 on `dq_out`.
- R3: Once a column is latched, later address changes are ignored and a second strobe falling reuses the latched column. A new column is taken only after both strobes have been seen high.
- R4: Before the first column strobe edge is sampled, the column path is transparent. Read data follows `addr` in the same cycle that the strobe goes low.
- R5: If `we_n` is low when the first column strobe falls, the cycle is an early write. `dq_in` is captured at that edge, and a lane whose strobe falls later in the same cycle is written with the captured data. Both lanes stay undriven for the whole column cycle.
- R6: If a column strobe is already low and latched when `we_n` falls, `dq_in` is written at that edge into the lanes whose strobe is low.
- R7: A lane drives only while the row strobe, that lane's column strobe and `oe_n` are all low. It stops as soon as `oe_n` or that strobe goes high.
- R8: A row strobe fall while a column strobe was low at the previous sample starts a refresh. `addr` and `dq_in` are ignored, nothing is driven, the memory is unchanged, and `refresh_row` increments by one.
- R9: `refresh_row` resets to 0, changes only at refresh entry, and wraps from 511 to 0.
- R10: A row strobe low with both column strobes high drives nothing and writes nothing, even with `we_n` and `oe_n` low.
- R11: `strobe_err` pulses high for one cycle when a column strobe rises while the row strobe is high, provided that strobe fell while the row strobe was high. It stays low when such a strobe is followed by a row strobe fall, which is a refresh setup.
- R12: After reset, all memory words read 0, `dq_oe` is 0, `refresh_row` is 0 and `strobe_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero on undriven lanes |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 lower, bit 1 upper) |
| refresh_row | output | 9 | Internal refresh row counter |
| strobe_err | output | 1 | One-cycle pulse on an abandoned column strobe |

## Verification
Reads are tried with both lanes, with the lower lane only and with the upper lane only, so a swapped or merged lane mask shows up. Write patterns differ in where the data is taken: both lanes falling together, staggered strobes with `dq_in` changed between the falls, and a `we_n` fall after the strobe. These separate capture at the first strobe edge from capture at a later edge. Page-mode sequences change the address with one strobe held low, and then change it after a full strobe release, to tell column reuse apart from a fresh latch. Refresh sequences drive a garbage address, write data and low enables, and then read back neighbouring words, to show that both refresh kinds leave the array and the bus alone.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_OPEN    = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_mode_e;

    // raw active-low control pins that need edge detection
    typedef struct packed {
        logic ras_n;
        logic lcas_n;
        logic ucas_n;
        logic we_n;
    } strobe_pins_t;

    typedef struct packed {
        logic             ras_fall;
        logic             ras_rise;
        logic [LANES-1:0] cas_fall;
        logic [LANES-1:0] cas_rise;
        logic             we_fall;
    } strobe_edges_t;

    // lane 0 = lower strobe, lane 1 = upper strobe
    function automatic logic [LANES-1:0] cas_active(strobe_pins_t p);
        return {~p.ucas_n, ~p.lcas_n};
    endfunction

endpackage

// File: rtl/dms_pin_sampler.sv
module dms_pin_sampler
    import dram_model_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  strobe_pins_t     pins,
    output logic [LANES-1:0] cas_low_prev,
    output strobe_edges_t    edges
);
    strobe_pins_t     prev_q;
    logic [LANES-1:0] low_now;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= pins;
    end

    always_comb begin
        low_now        = cas_active(pins);
        cas_low_prev   = cas_active(prev_q);
        edges.ras_fall = prev_q.ras_n & ~pins.ras_n;
        edges.ras_rise = ~prev_q.ras_n & pins.ras_n;
        edges.cas_fall = low_now & ~cas_low_prev;
        edges.cas_rise = ~low_now & cas_low_prev;
        edges.we_fall  = prev_q.we_n & ~pins.we_n;
    end

endmodule

// File: rtl/dms_cycle_ctrl.sv
module dms_cycle_ctrl
    import dram_model_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  cas_low_now,
    input  logic [LANES-1:0]  cas_low_prev,
    input  strobe_edges_t     edg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output cyc_mode_e         mode,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_eff,
    output logic              early_now,
    output logic [LANES-1:0]  wr_lane,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] refresh_row,
    output logic              strobe_err
);
    logic [ADDR_W-1:0] col_q;
    logic              col_held;
    logic              early_q;
    logic [DATA_W-1:0] data_q;
    logic [LANES-1:0]  pend_q;
    logic              row_open;
    logic              first_fall;
    logic              cbr_entry;

    always_comb begin
        row_open   = (mode == CYC_OPEN) && !ras_n;
        first_fall = row_open && (cas_low_prev == '0) && (cas_low_now != '0);
        cbr_entry  = edg.ras_fall && (cas_low_prev != '0);
        col_eff    = col_held ? col_q : addr;
        early_now  = col_held ? early_q : ~we_n;
        wr_lane    = '0;
        wr_data    = dq_in;
        if (row_open) begin
            if (first_fall) begin
                if (!we_n) wr_lane = cas_low_now;
            end else if (col_held && early_q) begin
                wr_lane = edg.cas_fall & cas_low_now;
                wr_data = data_q;
            end else if (col_held && edg.we_fall) begin
                wr_lane = cas_low_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= CYC_IDLE;
            row_q       <= '0;
            col_q       <= '0;
            col_held    <= 1'b0;
            early_q     <= 1'b0;
            data_q      <= '0;
            refresh_row <= '0;
            pend_q      <= '0;
            strobe_err  <= 1'b0;
        end else begin
            strobe_err <= 1'b0;
            if (edg.ras_fall) begin
                col_held <= 1'b0;
                early_q  <= 1'b0;
                if (cbr_entry) begin
                    mode        <= CYC_REFRESH;
                    refresh_row <= refresh_row + ADDR_W'(1);
                end else begin
                    mode  <= CYC_OPEN;
                    row_q <= addr;
                end
            end else if (edg.ras_rise) begin
                mode     <= CYC_IDLE;
                col_held <= 1'b0;
                early_q  <= 1'b0;
            end else if (mode == CYC_OPEN) begin
                if (first_fall) begin
                    col_q    <= addr;
                    col_held <= 1'b1;
                    early_q  <= ~we_n;
                    data_q   <= dq_in;
                end else if (cas_low_now == '0) begin
                    col_held <= 1'b0;
                    early_q  <= 1'b0;
                end
            end
            for (int l = 0; l < LANES; l++) begin
                if (!ras_n) begin
                    pend_q[l] <= 1'b0;
                end else if (edg.cas_fall[l]) begin
                    pend_q[l] <= 1'b1;
                end else if (edg.cas_rise[l] && pend_q[l]) begin
                    pend_q[l]  <= 1'b0;
                    strobe_err <= 1'b1;
                end
            end
        end
    end

    // latched column cannot move while a strobe holds it
    assert_col_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (col_held && (cas_low_now != '0)) |=> $stable(col_q));

    // counter moves only on refresh entry
    assert_ref_step_R9: assert property (@(posedge clk) disable iff (rst)
        !cbr_entry |=> $stable(refresh_row));

    // error pulse only follows a sample with the row strobe high
    assert_err_ras_high_R11: assert property (@(posedge clk) disable iff (rst)
        strobe_err |-> $past(ras_n));

endmodule

// File: rtl/dms_lane_array.sv
module dms_lane_array
    import dram_model_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (wr_lane[l]) begin
                cells[idx] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = cells[idx];
    end

endmodule

// File: rtl/dram_dual_strobe.sv
module dram_dual_strobe
    import dram_model_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int ROW_KEEP = 4,
    parameter int COL_KEEP = 4,
    localparam int IDX_W   = ROW_KEEP + COL_KEEP,
    localparam int DATA_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic [ADDR_W-1:0] refresh_row,
    output logic              strobe_err
);
    strobe_pins_t      pins;
    strobe_edges_t     edg;
    logic [LANES-1:0]  cas_low_now;
    logic [LANES-1:0]  cas_low_prev;
    cyc_mode_e         mode;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_eff;
    logic              early_now;
    logic [LANES-1:0]  wr_lane;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [IDX_W-1:0]  idx;
    logic              unused_addr_hi;

    assign pins        = '{ras_n: ras_n, lcas_n: lcas_n, ucas_n: ucas_n, we_n: we_n};
    assign cas_low_now = cas_active(pins);
    assign idx         = {row_q[ROW_KEEP-1:0], col_eff[COL_KEEP-1:0]};
    assign unused_addr_hi = ^{row_q[ADDR_W-1:ROW_KEEP], col_eff[ADDR_W-1:COL_KEEP]};

    dms_pin_sampler u_sampler (
        .clk          (clk),
        .rst          (rst),
        .pins         (pins),
        .cas_low_prev (cas_low_prev),
        .edges        (edg)
    );

    dms_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ras_n        (ras_n),
        .we_n         (we_n),
        .cas_low_now  (cas_low_now),
        .cas_low_prev (cas_low_prev),
        .edg          (edg),
        .addr         (addr),
        .dq_in        (dq_in),
        .mode         (mode),
        .row_q        (row_q),
        .col_eff      (col_eff),
        .early_now    (early_now),
        .wr_lane      (wr_lane),
        .wr_data      (wr_data),
        .refresh_row  (refresh_row),
        .strobe_err   (strobe_err)
    );

    dms_lane_array #(.IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .wr_lane (wr_lane),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_drive
        assign dq_oe[l] = (mode == CYC_OPEN) && !ras_n && cas_low_now[l]
                          && !oe_n && !early_now;
        assign dq_out[l*LANE_W +: LANE_W] = dq_oe[l] ? rd_data[l*LANE_W +: LANE_W] : '0;
    end

    assert_lane_low_R2: assert property (@(posedge clk) disable iff (rst)
        (dq_oe[0] |-> !lcas_n) and (dq_oe[1] |-> !ucas_n));

    assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (dq_oe == '0));

    assert_early_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == CYC_OPEN && early_now) |-> (dq_oe == '0));

    assert_quiet_refresh_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == CYC_REFRESH) |-> (dq_oe == '0 && wr_lane == '0));

    assert_ras_only_R10: assert property (@(posedge clk) disable iff (rst)
        (lcas_n && ucas_n) |-> (dq_oe == '0 && wr_lane == '0));

endmodule

// File: tb/tb_dram_dual_strobe.sv
module tb_dram_dual_strobe;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [8:0]  refresh_row;
    logic        strobe_err;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;
    logic [15:0] ref_mem [256];
    logic [8:0]  exp_ref = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_dual_strobe dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .refresh_row(refresh_row),
        .strobe_err(strobe_err)
    );

    function automatic int widx(logic [8:0] r, logic [8:0] c);
        return int'({r[3:0], c[3:0]});
    endfunction

    function automatic logic [15:0] lane_mask(logic [1:0] lanes);
        return {{8{lanes[1]}}, {8{lanes[0]}}};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic open_row(input logic [8:0] r);
        addr = r; ras_n = 0;
        @(negedge clk);
    endtask

    task automatic model_write(input logic [8:0] r, input logic [8:0] c,
                               input logic [1:0] lanes, input logic [15:0] d);
        int i = widx(r, c);
        if (lanes[0]) ref_mem[i][7:0]  = d[7:0];
        if (lanes[1]) ref_mem[i][15:8] = d[15:8];
    endtask

    // R1 R2 R4 R3: read with transparent column, then address change is ignored
    task automatic t_read(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes);
        logic [15:0] exp;
        open_row(r);
        addr = c; oe_n = 0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1];
        exp = ref_mem[widx(r, c)] & lane_mask(lanes);
        #1;
        check("R2 lane enables", 32'(dq_oe), 32'(lanes));
        check("R4 transparent column read", 32'(dq_out), 32'(exp));
        @(negedge clk);
        addr = c ^ 9'h0F5;
        #1 check("R3 latched column ignores addr", 32'(dq_out), 32'(exp));
        idle();
    endtask

    // R5: early write, both strobes together
    task automatic t_early_write(input logic [8:0] r, input logic [8:0] c,
                                 input logic [1:0] lanes, input logic [15:0] d);
        open_row(r);
        addr = c; dq_in = d; we_n = 0; oe_n = 0;
        lcas_n = ~lanes[0]; ucas_n = ~lanes[1];
        #1 check("R5 early write hi-Z at strobe", 32'(dq_oe), 0);
        @(negedge clk);
        dq_in = ~d;
        #1 check("R5 early write hi-Z later", 32'(dq_oe), 0);
        model_write(r, c, lanes, d);
        idle();
    endtask

    // R5: staggered strobes, data held from first fall
    task automatic t_early_stagger(input logic [8:0] r, input logic [8:0] c,
                                   input logic [15:0] d);
        open_row(r);
        addr = c; dq_in = d; we_n = 0; oe_n = 0; lcas_n = 0;
        @(negedge clk);
        dq_in = 16'h0BAD; addr = c ^ 9'h003; ucas_n = 0;
        #1 check("R5 stagger hi-Z", 32'(dq_oe), 0);
        @(negedge clk);
        model_write(r, c, 2'b11, d);
        idle();
    endtask

    // R6: delayed write on W fall, lanes chosen
    task automatic t_delayed_write(input logic [8:0] r, input logic [8:0] c,
                                   input logic [1:0] lanes, input logic [15:0] d);
        open_row(r);
        addr = c; oe_n = 0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1];
        #1 check("R6 old data before W", 32'(dq_out), 32'(ref_mem[widx(r, c)] & lane_mask(lanes)));
        @(negedge clk);
        oe_n = 1; dq_in = d; we_n = 0;
        #1 check("R7 OE high stops drive", 32'(dq_oe), 0);
        @(negedge clk);
        model_write(r, c, lanes, d);
        we_n = 1; dq_in = 16'hFFFF; oe_n = 0;
        #1 check("R6 data after W fall", 32'(dq_out), 32'(ref_mem[widx(r, c)] & lane_mask(lanes)));
        idle();
    endtask

    // R3: page mode, second strobe reuses column, release takes new column
    task automatic t_page(input logic [8:0] r, input logic [8:0] c1, input logic [8:0] c2);
        open_row(r);
        addr = c1; oe_n = 0; lcas_n = 0;
        @(negedge clk);
        addr = c2; ucas_n = 0;
        #1 check("R3 second strobe reuses column", 32'(dq_out), 32'(ref_mem[widx(r, c1)]));
        @(negedge clk);
        lcas_n = 1; ucas_n = 1;
        #1 check("R7 strobes high stop drive", 32'(dq_oe), 0);
        @(negedge clk);
        addr = c2; lcas_n = 0; ucas_n = 0;
        #1 check("R3 new column after release", 32'(dq_out), 32'(ref_mem[widx(r, c2)]));
        @(negedge clk);
        oe_n = 1;
        #1 check("R7 OE high mid-page", 32'(dq_oe), 0);
        idle();
    endtask

    // R8: refresh with column strobe first
    task automatic t_cbr();
        lcas_n = 0;
        @(negedge clk);
        addr = 9'h1A3; ras_n = 0; oe_n = 0; we_n = 0; dq_in = 16'hDEAD;
        @(negedge clk);
        exp_ref = exp_ref + 9'd1;
        #1 check("R8 refresh no drive", 32'(dq_oe), 0);
        check("R8 refresh counter step", 32'(refresh_row), 32'(exp_ref));
        check("R11 no error on refresh setup", 32'(strobe_err), 0);
        idle();
    endtask

    // R10: row strobe only
    task automatic t_ras_only(input logic [8:0] r);
        open_row(r);
        we_n = 0; oe_n = 0; dq_in = 16'hBEEF; addr = 9'h002;
        @(negedge clk);
        #1 check("R10 no drive on RAS-only", 32'(dq_oe), 0);
        check("R10 counter untouched", 32'(refresh_row), 32'(exp_ref));
        idle();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        check("R12 reset dq_oe", 32'(dq_oe), 0);
        check("R12 reset refresh_row", 32'(refresh_row), 0);
        check("R12 reset strobe_err", 32'(strobe_err), 0);
        t_read(9'h005, 9'h009, 2'b11);

        t_early_write(9'h001, 9'h002, 2'b11, 16'hA55A);
        t_read(9'h001, 9'h002, 2'b11);
        t_early_write(9'h001, 9'h002, 2'b01, 16'h3377);
        t_read(9'h001, 9'h002, 2'b11);
        t_read(9'h001, 9'h002, 2'b10);
        t_read(9'h001, 9'h002, 2'b01);
        // R1 aliasing of high address bits
        t_early_write(9'h013, 9'h025, 2'b11, 16'h1234);
        t_read(9'h003, 9'h005, 2'b11);
        t_early_stagger(9'h007, 9'h00C, 16'hC3E1);
        t_read(9'h007, 9'h00C, 2'b11);

        t_early_write(9'h002, 9'h004, 2'b11, 16'h4444);
        t_early_write(9'h002, 9'h008, 2'b11, 16'h8888);
        t_page(9'h002, 9'h004, 9'h008);

        t_delayed_write(9'h00A, 9'h00B, 2'b11, 16'hF00D);
        t_delayed_write(9'h00A, 9'h00B, 2'b10, 16'h5A00);
        t_read(9'h00A, 9'h00B, 2'b11);

        t_cbr();
        t_ras_only(9'h001);
        t_read(9'h001, 9'h002, 2'b11);
        t_read(9'h003, 9'h005, 2'b11);
        t_read(9'h00A, 9'h00B, 2'b11);

        // R9 wrap over a full sweep
        for (int k = 0; k < 510; k++) begin
            lcas_n = 0; @(negedge clk);
            ras_n = 0;  @(negedge clk);
            idle();
            exp_ref = exp_ref + 9'd1;
        end
        check("R9 count before wrap", 32'(refresh_row), 32'd511);
        t_cbr();
        check("R9 wrap to zero", 32'(refresh_row), 0);
        t_read(9'h007, 9'h00C, 2'b11);

        // R11 abandoned strobe
        lcas_n = 0; @(negedge clk);
        #1 check("R11 no pulse at fall", 32'(strobe_err), 0);
        lcas_n = 1; @(negedge clk);
        #1 check("R11 pulse on abandoned strobe", 32'(strobe_err), 1);
        @(negedge clk);
        #1 check("R11 pulse one cycle", 32'(strobe_err), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule